// File: doc/BRIEF.md
# HD Serial-Digital Descrambler and Word Framer

This block sits right after the deserialiser of a high-definition serial digital video receiver. Each clock it takes one 20-bit parallel word. The word is still NRZI coded, still carries self-synchronising scrambling, and has an arbitrary bit slip. The block removes the NRZI coding and then the scrambling. It then watches the recovered bit stream for the timing reference sequence. On each channel that sequence is one all-ones word followed by two all-zero words. With the two channels interleaved, it appears as one 20-bit all-ones word followed by two 20-bit all-zero words, and it may start at any of 20 bit offsets. Once the sequence is found, the block shifts the data so that each output word carries luma in bits 19:10 and chroma in bits 9:0.

Bit 0 of each input word is the earliest bit in transmission order. Two controls each bypass one stage: one bypasses the descrambling stage and the other bypasses the framing stage. A noise-immune option stops a single corrupted reference sequence from moving the word boundary.

Alignment is driven by a four-state machine:
- HUNT: no boundary is known.
- TRIAL: no boundary is known, and a candidate offset is pending confirmation.
- LOCK: the boundary is known.
- CHECK: the boundary is known, and a different candidate offset is pending.

The transitions, each taken on a detected reference sequence, are:
- HUNT→LOCK when noise immunity is off, and HUNT→TRIAL when it is on.
- TRIAL→LOCK when the candidate offset repeats or noise immunity is off. Otherwise TRIAL→TRIAL with a new candidate.
- LOCK→LOCK when the offset matches the current boundary, or when noise immunity is off (the boundary is then moved). LOCK→CHECK when noise immunity is on and the offset differs.
- CHECK→LOCK when the offset matches the current boundary, when it matches the candidate (the boundary is moved), or when noise immunity is off. Otherwise CHECK→CHECK with a new candidate.
- Any state→HUNT while framing is bypassed.

Top module: `sdi_deframer`

## Requirements
- R1: A synchronous active-high reset clears the output word to zero, clears both flags, clears the descrambler history to zero and puts the aligner in HUNT with offset zero.
- R2: Descrambling runs in two steps. First, NRZI decoding: each decoded bit is the received bit XOR the previously received bit. Second, each output bit is the decoded bit XOR the decoded bits 4 and 9 positions earlier. Bit 0 of every word is the earliest in time.
- R3: With the descrambler bypassed, the received bits are used as already decoded. The framer still aligns them.
- R4: A reference sequence is 20 consecutive ones followed by 40 zeros in the recovered stream. It is searched at all 20 offsets of the window. The output flag dout_trs is high exactly on the cycle when the aligned all-ones word is on dout and that sequence sits on the offset in use.
- R5: With noise immunity off, every detected reference sequence sets the offset in use to its own position.
- R6: With noise immunity on, the offset changes only when two consecutive detected sequences share the same new position. A sequence found at the current offset cancels a pending candidate. No flag is raised for an unconfirmed sequence.
- R7: dout_valid stays low until a detected sequence is accepted. Before that, the offset is zero.
- R8: With framing bypassed, the offset is zero and dout_valid is high. dout_trs is raised only for a sequence lying at offset zero.
- R9: dout holds the 20 recovered bits that start at the offset in use, with luma in bits 19:10 and chroma in bits 9:0, four clocks after the word holding their first bit was received.
- R10: With both stages bypassed, dout equals din delayed by four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 20 | Received word, bit 0 earliest |
| bypass_descr | input | 1 | Skip NRZI decoding and descrambling |
| bypass_frame | input | 1 | Skip word alignment |
| noise_immune | input | 1 | Require two matching sequences before moving the boundary |
| dout | output | 20 | Aligned word: luma 19:10, chroma 9:0 |
| dout_valid | output | 1 | A word boundary is established |
| dout_trs | output | 1 | dout is the all-ones word of an aligned reference sequence |

## Verification
The bench encodes randomly generated lines with a scrambler and NRZI encoder of its own, and it splices extra bits into the stream part-way through so that the boundary jumps.
- **Descrambler taps.** A descrambler with wrong taps or a bit order slipped by one stops reproducing the payload after the first few bits.
- **Realignment after a jump.** With noise immunity off, a design that fails to realign keeps emitting words at the old offset after the jump.
- **Noise-immune confirmation.** With noise immunity on, a design that moves on the first new sequence, or that never confirms, shows the wrong data and a flag raised or missing in the cycles between the two sequences.
- **Bypass paths.** The bypass phases catch a framer that still shifts data or holds dout_valid low when framing is bypassed.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    // Scrambler polynomial x^9 + x^4 + 1: tap distances in bit times
    localparam int SCR_TAP_NEAR = 4;
    localparam int SCR_TAP_FAR  = 9;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_LOCK  = 2'd2,
        ST_CHECK = 2'd3
    } align_st_t;

endpackage

// File: rtl/sdi_descrambler.sv
module sdi_descrambler
    import sdi_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bypass,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int HIST = SCR_TAP_FAR;

    logic            prev_q;
    logic [HIST-1:0] hist_q;
    logic [W-1:0]    nrz;
    logic [W-1:0]    dsc;
    logic [W+HIST-1:0] ext;

    always_comb begin
        nrz[0] = din[0] ^ prev_q;
        for (int i = 1; i < W; i++) begin
            nrz[i] = din[i] ^ din[i-1];
        end
        ext = {nrz, hist_q};
        for (int i = 0; i < W; i++) begin
            dsc[i] = ext[i+HIST] ^ ext[i+HIST-SCR_TAP_NEAR] ^ ext[i+HIST-SCR_TAP_FAR];
        end
        dout = bypass ? din : dsc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            hist_q <= '0;
        end else begin
            prev_q <= din[W-1];
            hist_q <= nrz[W-1 -: HIST];
        end
    end

endmodule

// File: rtl/sdi_trs_search.sv
module sdi_trs_search #(
    parameter  int W  = 20,
    localparam int OW = $clog2(W)
) (
    input  logic [4*W-2:0] win,
    output logic           hit,
    output logic [OW-1:0]  pos
);
    logic [W-1:0] hits;

    for (genvar k = 0; k < W; k++) begin : g_off
        assign hits[k] = (&win[k +: W]) & ~(|win[k+W +: 2*W]);
    end

    always_comb begin
        pos = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) pos = OW'(k);
        end
        hit = |hits;
    end

    // R4
    always_comb begin
        hits_unique_chk: assert ($onehot0(hits));
    end

endmodule

// File: rtl/sdi_align_fsm.sv
module sdi_align_fsm
    import sdi_pkg::*;
#(
    parameter  int W  = 20,
    localparam int OW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          noise_immune,
    input  logic          bypass,
    input  logic          hit,
    input  logic [OW-1:0] pos,
    output logic [OW-1:0] sel_off,
    output logic          valid_n,
    output logic          trs_n
);
    align_st_t     st_q, st_n;
    logic [OW-1:0] off_q, off_n;
    logic [OW-1:0] cand_q, cand_n;
    logic          locked_q;

    assign locked_q = (st_q == ST_LOCK) || (st_q == ST_CHECK);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            off_q  <= '0;
            cand_q <= '0;
        end else begin
            st_q   <= st_n;
            off_q  <= off_n;
            cand_q <= cand_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st_q;
        off_n  = off_q;
        cand_n = cand_q;
        if (bypass) begin
            st_n  = ST_HUNT;
            off_n = '0;
        end else if (hit) begin
            unique case (st_q)
                ST_HUNT: begin
                    if (noise_immune) begin
                        st_n   = ST_TRIAL;
                        cand_n = pos;
                    end else begin
                        st_n  = ST_LOCK;
                        off_n = pos;
                    end
                end
                ST_TRIAL: begin
                    if (!noise_immune || pos == cand_q) begin
                        st_n  = ST_LOCK;
                        off_n = pos;
                    end else begin
                        cand_n = pos;
                    end
                end
                ST_LOCK: begin
                    if (pos != off_q) begin
                        if (noise_immune) begin
                            st_n   = ST_CHECK;
                            cand_n = pos;
                        end else begin
                            off_n = pos;
                        end
                    end
                end
                ST_CHECK: begin
                    if (pos == off_q) begin
                        st_n = ST_LOCK;
                    end else if (!noise_immune || pos == cand_q) begin
                        st_n  = ST_LOCK;
                        off_n = pos;
                    end else begin
                        cand_n = pos;
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        sel_off = off_n;
        valid_n = bypass || (st_n == ST_LOCK) || (st_n == ST_CHECK);
        trs_n   = hit && (pos == off_n) && valid_n;
    end

    // R7
    nolock_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_q && !hit |=> !locked_q);

    // R5
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        !noise_immune && !bypass && hit |=> off_q == $past(pos));

    // R6
    ni_hold_chk: assert property (@(posedge clk) disable iff (rst)
        noise_immune && !bypass && st_q == ST_LOCK && hit |=> $stable(off_q));

    // R8
    byp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |=> off_q == '0);

endmodule

// File: rtl/sdi_deframer.sv
module sdi_deframer #(
    parameter  int CH_W = 10,
    localparam int W    = 2 * CH_W,
    localparam int OW   = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         bypass_descr,
    input  logic         bypass_frame,
    input  logic         noise_immune,
    output logic [W-1:0] dout,
    output logic         dout_valid,
    output logic         dout_trs
);
    logic [W-1:0]   dsc;
    logic [4*W-1:0] win_q;
    logic           hit;
    logic [OW-1:0]  pos;
    logic [OW-1:0]  sel_off;
    logic           valid_n;
    logic           trs_n;

    sdi_descrambler #(.W(W)) u_dsc (
        .clk    (clk),
        .rst    (rst),
        .bypass (bypass_descr),
        .din    (din),
        .dout   (dsc)
    );

    sdi_trs_search #(.W(W)) u_srch (
        .win (win_q[4*W-2:0]),
        .hit (hit),
        .pos (pos)
    );

    sdi_align_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .noise_immune (noise_immune),
        .bypass       (bypass_frame),
        .hit          (hit),
        .pos          (pos),
        .sel_off      (sel_off),
        .valid_n      (valid_n),
        .trs_n        (trs_n)
    );

    // window: newest word at the top, earliest bit at index 0
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q      <= '0;
            dout       <= '0;
            dout_valid <= 1'b0;
            dout_trs   <= 1'b0;
        end else begin
            win_q      <= {dsc, win_q[4*W-1:W]};
            dout       <= win_q[sel_off +: W];
            dout_valid <= valid_n;
            dout_trs   <= trs_n;
        end
    end

    // R4
    trs_ones_chk: assert property (@(posedge clk) disable iff (rst)
        dout_trs |-> &dout);

    // R8
    byp_valid_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_frame |=> dout_valid);

endmodule

// File: tb/sim_sdi_deframer.sv
module sim_sdi_deframer;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         bypass_descr = 1'b0;
    logic         bypass_frame = 1'b0;
    logic         noise_immune = 1'b0;
    logic [W-1:0] dout;
    logic         dout_valid;
    logic         dout_trs;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit            dq[$];
    int            tp[$];
    logic [W-1:0]  wq[$];

    // model state
    bit mlock, mcv;
    int mk, mcand;

    always #10 clk = ~clk;

    sdi_deframer u0 (
        .clk          (clk),
        .rst          (rst),
        .din          (din),
        .bypass_descr (bypass_descr),
        .bypass_frame (bypass_frame),
        .noise_immune (noise_immune),
        .dout         (dout),
        .dout_valid   (dout_valid),
        .dout_trs     (dout_trs)
    );

    task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    task automatic push_word(logic [W-1:0] w);
        for (int i = 0; i < W; i++) dq.push_back(w[i]);
    endtask

    task automatic push_junk(int n);
        for (int i = 0; i < n; i++) dq.push_back(bit'($urandom % 2));
    endtask

    task automatic push_line();
        logic [W-1:0] w;
        tp.push_back(dq.size());
        push_word('1);
        push_word('0);
        push_word('0);
        w = W'($urandom) | 20'h00001;
        w[W-1] = 1'b0;
        push_word(w);
        for (int j = 0; j < 16; j++) begin
            w = W'($urandom);
            if (&w) w[3] = 1'b0;
            push_word(w);
        end
    endtask

    // scrambler x^9+x^4+1 then NRZI encoder, bit 0 first
    task automatic build(bit scr);
        bit sv[$];
        bit txp;
        logic [W-1:0] w;
        while (dq.size() % W != 0) dq.push_back(bit'($urandom % 2));
        push_junk(5 * W);
        wq.delete();
        txp = 1'b0;
        w = '0;
        for (int t = 0; t < dq.size(); t++) begin
            bit sb, tb;
            sb = dq[t] ^ (t >= 4 ? sv[t-4] : 1'b0) ^ (t >= 9 ? sv[t-9] : 1'b0);
            sv.push_back(sb);
            tb = scr ? (sb ^ txp) : dq[t];
            txp = tb;
            w[t % W] = tb;
            if (t % W == W - 1) wq.push_back(w);
        end
    endtask

    function automatic bit dbit(int i);
        if (i < 0 || i >= dq.size()) return 1'b0;
        return dq[i];
    endfunction

    task automatic check_cycle(int m, string tag, bit fb, bit ni);
        int b, kk;
        bit det, trs_e;
        logic [W-1:0] exp;
        if (m < 4) return;
        b = W * (m - 4);
        det = 0;
        kk = 0;
        foreach (tp[j]) begin
            if (tp[j] >= b && tp[j] < b + W) begin
                det = 1;
                kk = tp[j] - b;
            end
        end
        trs_e = 0;
        if (fb) begin
            mk = 0; mlock = 1; trs_e = det && kk == 0;
        end else if (det) begin
            if (!ni) begin
                mk = kk; mlock = 1; mcv = 0; trs_e = 1;
            end else if (mlock && kk == mk) begin
                mcv = 0; trs_e = 1;
            end else if (mcv && mcand == kk) begin
                mk = kk; mlock = 1; mcv = 0; trs_e = 1;
            end else begin
                mcand = kk; mcv = 1;
            end
        end
        for (int i = 0; i < W; i++) exp[i] = dbit(b + mk + i);
        chk(dout == exp, {tag, " data R9"}, dout, exp);
        chk(dout_valid == mlock, mlock ? {tag, " valid"} : "R7 valid before lock",
            W'(dout_valid), W'(mlock));
        chk(dout_trs == trs_e, {tag, " R4 flag"}, W'(dout_trs), W'(trs_e));
    endtask

    task automatic run_phase(string tag, bit bd, bit fb, bit ni);
        build(!bd);
        rst = 1'b1;
        bypass_descr = bd;
        bypass_frame = fb;
        noise_immune = ni;
        repeat (3) @(negedge clk);
        chk(dout == '0, "R1 dout reset", dout, '0);
        chk(dout_valid == 1'b0, "R1 valid reset", W'(dout_valid), '0);
        chk(dout_trs == 1'b0, "R1 flag reset", W'(dout_trs), '0);
        mlock = 0; mcv = 0; mk = 0; mcand = 0;
        for (int n = 0; n <= wq.size(); n++) begin
            @(negedge clk);
            if (n > 0) check_cycle(n - 1, tag, fb, ni);
            rst = 1'b0;
            if (n < wq.size()) din = wq[n];
        end
        rst = 1'b1;
        dq.delete();
        tp.delete();
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R2 and R5: scrambled, realign on every sequence, boundary jump
        push_junk(7);
        repeat (3) push_line();
        push_junk(5);
        repeat (3) push_line();
        run_phase("R2 R5", 1'b0, 1'b0, 1'b0);
        // R6: noise immune, jump by 9 bits needs two sequences
        push_junk(3);
        repeat (2) push_line();
        push_junk(9);
        repeat (3) push_line();
        run_phase("R6", 1'b0, 1'b0, 1'b1);
        // R3: descrambler bypassed, framer active
        push_junk(15);
        repeat (3) push_line();
        run_phase("R3", 1'b1, 1'b0, 1'b0);
        // R10: both bypassed
        push_junk(6);
        repeat (2) push_line();
        run_phase("R10", 1'b1, 1'b1, 1'b0);
        // R8: framer bypassed, sequences at offset zero then off zero
        repeat (2) push_line();
        push_junk(4);
        push_line();
        run_phase("R8", 1'b0, 1'b1, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule